// File: doc/BRIEF.md
# Transmit Buffer-Bypass Alignment Sequencer

This block controls phase and delay alignment for a serial transmitter that runs with its elastic buffer bypassed. Each alignment run begins with a reset pulse on the alignment logic. The block then waits for the alignment-complete status from the transmitter. Once that status has risen, the block reports the link as aligned. It keeps watching the status while delay alignment continues to track temperature and voltage drift.

A new run is started when any of four clocking events is reported: transmitter reset or power-up, PLL reset, a change of reference clock, or a change of line rate. A run never begins while the PLL is unlocked. Two conditions count as a sequence violation: the completion status does not rise within a timeout, or it falls while the block is aligned. On a violation the block pulses a full transmitter reset, increments a saturating error count and then starts the procedure again.

All inputs except the completion status are synchronous to the control clock. The completion status passes through a two-stage synchronizer. The reset `rst_n` is asserted asynchronously and is expected to be released synchronously to `clk`.

Top module: `txbb_align_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards until `pll_lock` is seen high, `phdly_rst_o`, `tx_rst_o` and `aligned_o` are 0. During that time `err_cnt_o` is 0.
- R2: Each run starts the cycle after `pll_lock` is sampled high while waiting. `phdly_rst_o` then stays high for exactly `RST_CYC` cycles.
- R3: A one-cycle pulse on any of `ev_txrst`, `ev_pllrst`, `ev_refclk` or `ev_rate` clears `aligned_o` on the next cycle and starts a fresh run.
- R4: A run completes only on a rising edge of the synchronized completion status. A status that is already high when the run starts never completes the run.
- R5: `aligned_o` rises exactly three clock edges after the edge that first samples `align_done_a` high: two synchronizer stages plus one state register.
- R6: If no rising edge arrives within `TMO_CYC` cycles after `phdly_rst_o` falls, `tx_rst_o` goes high for exactly `TXRST_CYC` cycles and `err_cnt_o` increments.
- R7: If the synchronized status falls while the block is aligned, `tx_rst_o` rises three edges after the low level is first sampled and `err_cnt_o` increments.
- R8: While aligned, and with no event and the status held high, no alignment reset is issued and `aligned_o` stays high.
- R9: `err_cnt_o` increments by one per violation and saturates at 255.
- R10: An event strobe that arrives during a `tx_rst_o` pulse is ignored. The pulse keeps its full `TXRST_CYC` width.
- R11: If an event and a status-fall violation fall in the same cycle, the event wins. No transmitter reset is issued and `err_cnt_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running control clock |
| rst_n | input | 1 | Active-low system reset |
| ev_txrst | input | 1 | Strobe: transmitter reset or power-up |
| ev_pllrst | input | 1 | Strobe: PLL reset or power-up |
| ev_refclk | input | 1 | Strobe: reference clock source or frequency change |
| ev_rate | input | 1 | Strobe: line rate change |
| pll_lock | input | 1 | PLL locked flag |
| align_done_a | input | 1 | Asynchronous alignment-complete status |
| phdly_rst_o | output | 1 | Phase/delay alignment reset pulse |
| tx_rst_o | output | 1 | Full transmitter reset pulse |
| aligned_o | output | 1 | Alignment complete and holding |
| err_cnt_o | output | 8 | Saturating sequence-violation count |

## Verification
The assertions take three things for granted about the inputs. Event strobes are synchronous single-cycle pulses. `pll_lock` is stable around the edge that samples it. The completion status changes slowly enough that the synchronizer delivers each level for at least one cycle. The stimulus drives every input on the falling clock edge and holds the status for many cycles between changes. It pulses each event strobe for exactly one cycle, and times collisions, such as an event arriving with a status fall, by counting edges through the synchronizer rather than by racing it.

// File: rtl/txbb_align_pkg.sv
package txbb_align_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_LOCK = 3'd0,
    ST_PHRST     = 3'd1,
    ST_WAIT_DONE = 3'd2,
    ST_ALIGNED   = 3'd3,
    ST_TXRST     = 3'd4
  } seq_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/txbb_done_sync.sv
module txbb_done_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic done_a,
  output logic done_lvl,
  output logic done_rise
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], done_a};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign done_lvl  = sync_q[STAGES-1];
  assign done_rise = sync_q[STAGES-1] & ~last_q;

  // R4: a detected edge lasts a single cycle
  a_r4_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    done_rise |=> !done_rise);

endmodule

// File: rtl/txbb_event_merge.sv
module txbb_event_merge #(
  parameter int unsigned NUM_EV = 4
) (
  input  logic [NUM_EV-1:0] ev,
  output logic              trig
);

  logic [NUM_EV:0] chain;

  assign chain[0] = 1'b0;

  for (genvar i = 0; i < NUM_EV; i++) begin : g_or
    assign chain[i+1] = chain[i] | ev[i];
  end

  assign trig = chain[NUM_EV];

endmodule

// File: rtl/txbb_err_ctr.sv
module txbb_err_ctr #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = inc && (cnt_q != CNT_MAX);
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  a_r9_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/txbb_align_seq.sv
module txbb_align_seq
  import txbb_align_pkg::*;
#(
  parameter int unsigned RST_CYC   = 16,
  parameter int unsigned TMO_CYC   = 65536,
  parameter int unsigned TXRST_CYC = 32,
  parameter int unsigned ERR_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_txrst,
  input  logic             ev_pllrst,
  input  logic             ev_refclk,
  input  logic             ev_rate,
  input  logic             pll_lock,
  input  logic             align_done_a,
  output logic             phdly_rst_o,
  output logic             tx_rst_o,
  output logic             aligned_o,
  output logic [ERR_W-1:0] err_cnt_o
);

  localparam int unsigned NUM_EV   = 4;
  localparam int unsigned MAX_SPAN = max3(RST_CYC, TMO_CYC, TXRST_CYC);
  localparam int unsigned CNT_W    = $clog2(MAX_SPAN + 1);
  localparam logic [CNT_W-1:0] RST_LAST   = CNT_W'(RST_CYC - 1);
  localparam logic [CNT_W-1:0] TMO_LAST   = CNT_W'(TMO_CYC - 1);
  localparam logic [CNT_W-1:0] TXRST_LAST = CNT_W'(TXRST_CYC - 1);

  logic done_lvl;
  logic done_rise;
  logic trig;
  logic viol;

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  txbb_done_sync #(.STAGES(2)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_a    (align_done_a),
    .done_lvl  (done_lvl),
    .done_rise (done_rise)
  );

  txbb_event_merge #(.NUM_EV(NUM_EV)) u_evt (
    .ev   ({ev_rate, ev_refclk, ev_pllrst, ev_txrst}),
    .trig (trig)
  );

  txbb_err_ctr #(.W(ERR_W)) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (viol),
    .cnt   (err_cnt_o)
  );

  // next-state logic
  always_comb begin
    st_d = st_q;
    viol = 1'b0;
    unique case (st_q)
      ST_WAIT_LOCK: begin
        if (pll_lock) st_d = ST_PHRST;
      end
      ST_PHRST: begin
        if (trig)                   st_d = ST_WAIT_LOCK;
        else if (cnt_q == RST_LAST) st_d = ST_WAIT_DONE;
      end
      ST_WAIT_DONE: begin
        if (trig)           st_d = ST_WAIT_LOCK;
        else if (done_rise) st_d = ST_ALIGNED;
        else if (cnt_q == TMO_LAST) begin
          st_d = ST_TXRST;
          viol = 1'b1;
        end
      end
      ST_ALIGNED: begin
        if (trig) st_d = ST_WAIT_LOCK;
        else if (!done_lvl) begin
          st_d = ST_TXRST;
          viol = 1'b1;
        end
      end
      ST_TXRST: begin
        if (cnt_q == TXRST_LAST) st_d = ST_WAIT_LOCK;
      end
      default: st_d = ST_WAIT_LOCK;
    endcase
  end

  // interval counter: restarts on every state change, runs only in timed states
  always_comb begin
    cnt_en = (st_d != st_q) ||
             (st_q == ST_PHRST) || (st_q == ST_WAIT_DONE) || (st_q == ST_TXRST);
    cnt_d  = (st_d != st_q) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_WAIT_LOCK;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign phdly_rst_o = (st_q == ST_PHRST);
  assign tx_rst_o    = (st_q == ST_TXRST);
  assign aligned_o   = (st_q == ST_ALIGNED);

  a_r2_lock_before_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phdly_rst_o) |-> $past(pll_lock));

  a_r3_event_clears_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !tx_rst_o) |=> !aligned_o);

  a_r5_aligned_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned_o) |-> $past(done_rise));

  a_r6_violation_counted: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_rst_o) |-> ((err_cnt_o != $past(err_cnt_o)) || ($past(err_cnt_o) == '1)));

  a_r1_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(phdly_rst_o && (tx_rst_o || aligned_o)));

endmodule

// File: tb/txbb_align_seq_tb_top.sv
`timescale 1ns/1ps
module txbb_align_seq_tb_top;

  localparam int RST_N   = 4;
  localparam int TMO_N   = 40;
  localparam int TXRST_N = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] ev_b;
  logic       pll_lock;
  logic       done_a;
  logic       phd, txr, alg;
  logic [7:0] err;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit cmp_on = 0;
  bit ended  = 0;

  always #2 clk = ~clk;

  txbb_align_seq #(.RST_CYC(RST_N), .TMO_CYC(TMO_N), .TXRST_CYC(TXRST_N), .ERR_W(8)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_txrst     (ev_b[0]),
    .ev_pllrst    (ev_b[1]),
    .ev_refclk    (ev_b[2]),
    .ev_rate      (ev_b[3]),
    .pll_lock     (pll_lock),
    .align_done_a (done_a),
    .phdly_rst_o  (phd),
    .tx_rst_o     (txr),
    .aligned_o    (alg),
    .err_cnt_o    (err)
  );

  // behavioural reference: phase 0 wait, 1 reset pulse, 2 wait done, 3 aligned, 4 tx reset
  int phase, left, merr;
  bit d1, d2, d3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase = 0; left = 0; merr = 0; d1 = 0; d2 = 0; d3 = 0;
    end else begin
      bit any_ev, edge_seen;
      any_ev    = |ev_b;
      edge_seen = d2 && !d3;
      case (phase)
        0: if (pll_lock) begin phase = 1; left = RST_N; end
        1: if (any_ev) phase = 0;
           else begin left--; if (left == 0) begin phase = 2; left = TMO_N; end end
        2: if (any_ev) phase = 0;
           else if (edge_seen) phase = 3;
           else begin
             left--;
             if (left == 0) begin phase = 4; left = TXRST_N; if (merr < 255) merr++; end
           end
        3: if (any_ev) phase = 0;
           else if (!d2) begin phase = 4; left = TXRST_N; if (merr < 255) merr++; end
        default: begin left--; if (left == 0) phase = 0; end
      endcase
      d3 = d2; d2 = d1; d1 = done_a;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // compare against the reference on every cycle, away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !ended) begin
      chk(phd == (phase == 1), "R2 phdly_rst", phd, phase == 1);
      chk(txr == (phase == 4), "R6 tx_rst", txr, phase == 4);
      chk(alg == (phase == 3), "R5 aligned", alg, phase == 3);
      chk(err == merr, "R9 err_cnt", err, merr);
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 190000 && !ended) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 190000);
      finish_run();
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic measure_phd(output int w);
    int guard = 0;
    w = 0;
    while (!phd && guard < 500) begin tick(); guard++; end
    while (phd && w < 500) begin tick(); w++; end
  endtask

  task automatic realign(input string req);
    int w;
    done_a = 1'b0;
    measure_phd(w);
    tick();
    done_a = 1'b1;
    repeat (3) tick();
    chk(alg == 1'b1, req, alg, 1);
  endtask

  initial begin
    int w, n, eb;
    bit bad;
    rst_n = 1'b0; ev_b = '0; pll_lock = 1'b0; done_a = 1'b0;
    repeat (3) tick();
    // R1: reset state
    chk(phd == 0 && txr == 0 && alg == 0, "R1 outputs in reset", {phd, txr, alg}, 0);
    chk(err == 0, "R1 err in reset", err, 0);
    rst_n = 1'b1;
    cmp_on = 1;
    repeat (10) tick();
    chk(phd == 0, "R1 no run without lock", phd, 0);
    pll_lock = 1'b1;

    // R2: pulse width
    measure_phd(w);
    chk(w == RST_N, "R2 phdly_rst width", w, RST_N);

    // R5: latency through synchronizer
    tick(); tick();
    done_a = 1'b1;
    tick(); tick();
    chk(alg == 0, "R5 aligned too early", alg, 0);
    tick();
    chk(alg == 1, "R5 aligned after three edges", alg, 1);

    // R8: steady aligned state
    bad = 0;
    repeat (100) begin tick(); if (phd || !alg) bad = 1; end
    chk(!bad, "R8 stays aligned quietly", bad, 0);

    // R3: each event restarts a run
    for (int i = 0; i < 4; i++) begin
      ev_b[i] = 1'b1; done_a = 1'b0;
      tick();
      ev_b = '0;
      chk(alg == 0, "R3 event clears aligned", alg, 0);
      measure_phd(w);
      chk(w == RST_N, "R3 restart pulse width", w, RST_N);
      tick();
      done_a = 1'b1;
      repeat (3) tick();
      chk(alg == 1, "R3 realigned after event", alg, 1);
    end

    // R4 and R6: status already high never completes; timeout escalates
    eb = err;
    ev_b[0] = 1'b1;
    tick();
    ev_b = '0;
    measure_phd(w);
    n = 0; bad = 0;
    while (!txr && n < 500) begin if (alg) bad = 1; tick(); n++; end
    chk(!bad, "R4 level does not complete", bad, 0);
    chk(n == TMO_N, "R6 timeout length", n, TMO_N);
    chk(err == eb + 1, "R6 err increment", err, eb + 1);
    w = 0;
    while (txr && w < 500) begin tick(); w++; end
    chk(w == TXRST_N, "R6 tx_rst width", w, TXRST_N);
    realign("R6 recovery realigns");

    // R7: status fall while aligned
    eb = err;
    done_a = 1'b0;
    tick(); tick();
    chk(txr == 0, "R7 no early tx_rst", txr, 0);
    tick();
    chk(txr == 1, "R7 tx_rst after fall", txr, 1);
    chk(err == eb + 1, "R7 err increment", err, eb + 1);
    while (txr) tick();
    realign("R7 recovery realigns");

    // R10: event during tx reset pulse ignored
    done_a = 1'b0;
    repeat (3) tick();
    w = 0;
    while (txr && w < 500) begin
      ev_b = (w == 1) ? 4'b0100 : 4'b0000;
      tick(); w++;
    end
    ev_b = '0;
    chk(w == TXRST_N, "R10 pulse keeps width", w, TXRST_N);
    realign("R10 recovery realigns");

    // R11: event and status fall collide
    eb = err;
    done_a = 1'b0;
    tick(); tick();
    ev_b[3] = 1'b1;
    tick();
    ev_b = '0;
    chk(txr == 0, "R11 no tx_rst on collision", txr, 0);
    chk(err == eb, "R11 err unchanged", err, eb);
    chk(alg == 0, "R11 aligned cleared", alg, 0);

    // R9: saturation
    n = 0;
    while (err != 8'd255 && n < 30000) begin tick(); n++; end
    chk(err == 255, "R9 reaches max", err, 255);
    while (txr) tick();
    n = 0;
    while (!txr && n < 500) begin tick(); n++; end
    chk(txr == 1, "R9 further violation occurs", txr, 1);
    chk(err == 255, "R9 saturates", err, 255);
    repeat (4) tick();
    finish_run();
  end

endmodule